// File: doc/BRIEF.md
# Triple-Redundancy Majority Voter with Reconfiguration Request

This block sits behind three identical copies of a functional unit. Every clock it takes the three data words, forms a bitwise two-out-of-three majority and registers it as the protected output. A fault confined to one copy therefore never reaches the output, and the vote runs without pause whether or not a repair is under way.

In parallel the block looks for trouble. A copy is suspect when it loses the vote on any bit, or when its own configuration checker raises its error line. A per-copy mask input can exclude individual checker lines, for example during bring-up. Any suspect copy raises a reconfiguration request that stays high until the repair logic acknowledges it. A three-bit suspect vector tells the repair logic which copies to reload. After an acknowledge the request logic waits for a fixed settling period while the reloaded copy comes back, and ignores triggers during that period. A saturating counter counts disagreement episodes for diagnostics.

The request logic is a three-state machine. IDLE: no request. PENDING: the request is high and suspects accumulate. SETTLE: the acknowledge has been taken and triggers are ignored. The transitions are IDLE to PENDING on any trigger, PENDING to SETTLE on an acknowledge, and SETTLE to IDLE when the settle timer has run out.

Top module: `tmr_reconfig_voter`

## Requirements
- R1: `voted_q` equals the bitwise majority of `copy_a`, `copy_b` and `copy_c` as sampled at the previous rising clock edge.
- R2: The voted output keeps following the majority, unaffected by the request state, while `reconfig_req` is high or the block is settling.
- R3: In IDLE, a data disagreement or an unmasked checker error sampled at an edge sets `reconfig_req` high at that edge. A data disagreement means any copy differs from the majority on any bit.
- R4: Once high, `reconfig_req` stays high until `reconfig_ack` is sampled high. An acknowledge sampled while no request is pending has no effect.
- R5: When an acknowledge is taken, `reconfig_req` and `suspect` go low at that edge. Triggers at the following SETTLE_CYC edges are ignored. The first trigger after that raises the request again.
- R6: `suspect` bit 0 stands for copy A, bit 1 for copy B and bit 2 for copy C. A bit is set when that copy lost the vote on any bit, or when its checker line is high and not masked. Bits accumulate by OR while the request is pending. `suspect` is zero whenever `reconfig_req` is low.
- R7: `mismatch_cnt` rises by one for each 0-to-1 change of the data-disagreement condition between consecutive edges. It holds at all ones once it gets there. Checker errors and acknowledges do not change it.
- R8: `err_pin_mask[i]` = 1 stops `crc_err[i]` from raising the request or marking copy i. Masking has no effect on data-disagreement detection.
- R9: While `rst_n` is low, `voted_q`, `reconfig_req`, `suspect` and `mismatch_cnt` are all zero and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| copy_a | input | DATA_W | Data output of copy A |
| copy_b | input | DATA_W | Data output of copy B |
| copy_c | input | DATA_W | Data output of copy C |
| crc_err | input | 3 | Configuration checker error per copy (bit 0 = A) |
| err_pin_mask | input | 3 | 1 excludes the matching `crc_err` bit |
| reconfig_ack | input | 1 | Acknowledge from the reconfiguration logic |
| voted_q | output | DATA_W | Registered majority result |
| reconfig_req | output | 1 | Reconfiguration request, held until acknowledged |
| suspect | output | 3 | Copies marked for reload (bit 0 = A) |
| mismatch_cnt | output | CNT_W | Saturating count of disagreement episodes |

## Verification
Every result of this block is due at the first rising edge after its inputs are sampled. This holds for the voted word, the request, the suspect bits and the counter. The settling window after an acknowledge covers the next SETTLE_CYC edges. The bench drives all inputs on the falling edge. Its reference model advances once per cycle and gives the values due at the next rising edge, and the bench compares those values 1 ns after that edge. Directed cases cover suspect accumulation, triggers inside and just after the settling window, masked checker lines, a stray acknowledge and counter saturation. Seeded random cycles then mix single-copy and double-copy corruption, checker errors, masks and acknowledges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned NUM_COPIES = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_SETTLE  = 2'd2
    } req_state_t;

endpackage

// File: rtl/tmr_bit_vote.sv
module tmr_bit_vote #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0]             in_a,
    input  logic [DATA_W-1:0]             in_b,
    input  logic [DATA_W-1:0]             in_c,
    output logic [DATA_W-1:0]             majority,
    output logic [tmr_pkg::NUM_COPIES-1:0] outvoted
);

    logic [DATA_W-1:0] lose_a;
    logic [DATA_W-1:0] lose_b;
    logic [DATA_W-1:0] lose_c;

    // One three-input majority cell per data bit.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign majority[gi] = (in_a[gi] & in_b[gi]) |
                              (in_a[gi] & in_c[gi]) |
                              (in_b[gi] & in_c[gi]);
        assign lose_a[gi] = in_a[gi] ^ majority[gi];
        assign lose_b[gi] = in_b[gi] ^ majority[gi];
        assign lose_c[gi] = in_c[gi] ^ majority[gi];
    end

    assign outvoted = {|lose_c, |lose_b, |lose_a};

endmodule

// File: rtl/tmr_req_fsm.sv
module tmr_req_fsm
    import tmr_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_COPIES-1:0] fault,
    input  logic                  ack,
    output logic                  req,
    output logic [NUM_COPIES-1:0] suspect
);

    localparam int unsigned TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    req_state_t        state;
    req_state_t        state_nx;
    logic [TW-1:0]     timer;
    logic              trig;

    assign trig = |fault;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (trig)        state_nx = ST_PENDING;
            ST_PENDING: if (ack)         state_nx = ST_SETTLE;
            ST_SETTLE:  if (timer == '0) state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // Settle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (state == ST_PENDING && ack) begin
            timer <= TW'(SETTLE_CYC - 1);
        end else if (state == ST_SETTLE && timer != '0) begin
            timer <= timer - 1'b1;
        end
    end

    // Suspect register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            suspect <= '0;
        end else begin
            unique case (state)
                ST_IDLE:    suspect <= trig ? fault : '0;
                ST_PENDING: suspect <= ack ? '0 : (suspect | fault);
                ST_SETTLE:  suspect <= '0;
                default:    suspect <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req = 1'b0;
        unique case (state)
            ST_PENDING: req = 1'b1;
            default:    req = 1'b0;
        endcase
    end

    AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trig) |=> req);                               // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);                                            // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (!req && suspect == '0));                         // R5
    AST_SUSPECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (suspect != '0) |-> req);                                          // R6
    AST_SUSPECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ((suspect & $past(suspect)) == $past(suspect))); // R6

endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            count   <= '0;
        end else begin
            level_d <= level;
            if (level && !level_d && count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1));      // R7
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));                       // R7
    AST_CNT_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!level) |=> $stable(count));                                     // R7

endmodule

// File: rtl/tmr_reconfig_voter.sv
module tmr_reconfig_voter
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] copy_a,
    input  logic [DATA_W-1:0] copy_b,
    input  logic [DATA_W-1:0] copy_c,
    input  logic [2:0]        crc_err,
    input  logic [2:0]        err_pin_mask,
    input  logic              reconfig_ack,
    output logic [DATA_W-1:0] voted_q,
    output logic              reconfig_req,
    output logic [2:0]        suspect,
    output logic [CNT_W-1:0]  mismatch_cnt
);

    logic [DATA_W-1:0]     maj_w;
    logic [NUM_COPIES-1:0] outvoted_w;
    logic [NUM_COPIES-1:0] pin_live;
    logic [NUM_COPIES-1:0] fault_w;
    logic                  disagree_w;

    tmr_bit_vote #(.DATA_W(DATA_W)) u_vote (
        .in_a     (copy_a),
        .in_b     (copy_b),
        .in_c     (copy_c),
        .majority (maj_w),
        .outvoted (outvoted_w)
    );

    assign pin_live   = crc_err & ~err_pin_mask;
    assign fault_w    = outvoted_w | pin_live;
    assign disagree_w = |outvoted_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) voted_q <= '0;
        else        voted_q <= maj_w;
    end

    tmr_req_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault_w),
        .ack     (reconfig_ack),
        .req     (reconfig_req),
        .suspect (suspect)
    );

    tmr_event_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .level (disagree_w),
        .count (mismatch_cnt)
    );

    AST_VOTE_AB_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_a == copy_b) |=> (voted_q == $past(copy_a)));               // R1
    AST_VOTE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_req && copy_b == copy_c) |=> (voted_q == $past(copy_b))); // R2
    AST_MASKED_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!reconfig_req && copy_a == copy_b && copy_b == copy_c &&
         (crc_err & ~err_pin_mask) == 3'b000) |=> (suspect == 3'b000));  // R8

endmodule

// File: tb/sim_tmr_reconfig_voter.sv
module sim_tmr_reconfig_voter;

    localparam int unsigned W      = 8;
    localparam int unsigned CW     = 4;
    localparam int unsigned SETTLE = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  copy_a = '0, copy_b = '0, copy_c = '0;
    logic [2:0]    crc_err = '0, err_pin_mask = '0;
    logic          reconfig_ack = 1'b0;
    logic [W-1:0]  voted_q;
    logic          reconfig_req;
    logic [2:0]    suspect;
    logic [CW-1:0] mismatch_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference model state
    bit            m_req;
    bit [2:0]      m_susp;
    int            m_hold;
    bit [CW-1:0]   m_cnt;
    bit            m_prev;

    always #4 clk = ~clk;

    tmr_reconfig_voter #(.DATA_W(W), .CNT_W(CW), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .copy_a(copy_a), .copy_b(copy_b), .copy_c(copy_c),
        .crc_err(crc_err), .err_pin_mask(err_pin_mask), .reconfig_ack(reconfig_ack),
        .voted_q(voted_q), .reconfig_req(reconfig_req), .suspect(suspect),
        .mismatch_cnt(mismatch_cnt)
    );

    function automatic logic [W-1:0] f_maj(input logic [W-1:0] a, b, c);
        logic [W-1:0] r;
        for (int i = 0; i < int'(W); i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
        return r;
    endfunction

    function automatic logic [2:0] f_lost(input logic [W-1:0] a, b, c);
        logic [W-1:0] m;
        m = f_maj(a, b, c);
        return {c != m, b != m, a != m};
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] act, exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        copy_a = '0; copy_b = '0; copy_c = '0;
        crc_err = '0; err_pin_mask = '0; reconfig_ack = 1'b0;
        m_req = 0; m_susp = '0; m_hold = 0; m_cnt = '0; m_prev = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R9", "reset voted", 32'(voted_q), 0);
        check("R9", "reset req", 32'(reconfig_req), 0);
        check("R9", "reset suspect", 32'(suspect), 0);
        check("R9", "reset count", 32'(mismatch_cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [W-1:0] a, b, c, input logic [2:0] crc, msk,
                        input logic ack);
        logic [W-1:0] mj;
        logic [2:0]   lost, flt;
        logic         mis, was_req;
        string        req_tag;
        @(negedge clk);
        copy_a = a; copy_b = b; copy_c = c;
        crc_err = crc; err_pin_mask = msk; reconfig_ack = ack;
        mj   = f_maj(a, b, c);
        lost = f_lost(a, b, c);
        mis  = |lost;
        flt  = lost | (crc & ~msk);
        was_req = m_req;
        if (m_req) begin
            if (ack) begin m_req = 0; m_susp = '0; m_hold = SETTLE; req_tag = "R5"; end
            else begin m_susp = m_susp | flt; req_tag = "R4"; end
        end else if (m_hold > 0) begin
            m_hold--; req_tag = "R5";
        end else begin
            req_tag = ((crc & msk) != 0) ? "R8" : "R3";
            if (flt != 0) begin m_req = 1; m_susp = flt; end
        end
        if (mis && !m_prev && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
        m_prev = mis;
        @(posedge clk);
        #1;
        check(was_req ? "R2" : "R1", "voted", 32'(voted_q), 32'(mj));
        check(req_tag, "request", 32'(reconfig_req), 32'(m_req));
        check(((crc & msk) != 0) ? "R8" : "R6", "suspect", 32'(suspect), 32'(m_susp));
        check("R7", "count", 32'(mismatch_cnt), 32'(m_cnt));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] base;
        void'($urandom(32'd20240611));
        do_reset();

        // R3: agreement, no trigger
        step(8'h5A, 8'h5A, 8'h5A, 3'b000, 3'b000, 1'b0);
        // R3 / R6: copy B flips one bit
        step(8'h5A, 8'h5B, 8'h5A, 3'b000, 3'b000, 1'b0);
        // R4 / R7: fault held, no new episode counted
        step(8'h5A, 8'h5B, 8'h5A, 3'b000, 3'b000, 1'b0);
        // R6: copy C now loses too, suspects accumulate
        step(8'h5A, 8'h5A, 8'h1A, 3'b000, 3'b000, 1'b0);
        // R2: pending request, voting continues
        step(8'hC3, 8'hC3, 8'hC3, 3'b000, 3'b000, 1'b0);
        // R5: acknowledge clears
        step(8'hC3, 8'hC3, 8'hC3, 3'b000, 3'b000, 1'b1);
        // R5: triggers ignored during settle
        for (int i = 0; i < int'(SETTLE); i++)
            step(8'h11, 8'h11, 8'h11, 3'b001, 3'b000, 1'b0);
        // R5: first trigger after settle raises request
        step(8'h11, 8'h11, 8'h11, 3'b001, 3'b000, 1'b0);
        step(8'h11, 8'h11, 8'h11, 3'b000, 3'b000, 1'b1);
        for (int i = 0; i < int'(SETTLE); i++)
            step(8'h22, 8'h22, 8'h22, 3'b000, 3'b000, 1'b0);
        // R8: masked checker line ignored, then unmasked raises
        step(8'h33, 8'h33, 8'h33, 3'b100, 3'b100, 1'b0);
        step(8'h33, 8'h33, 8'h33, 3'b110, 3'b110, 1'b0);
        step(8'h33, 8'h33, 8'h33, 3'b100, 3'b000, 1'b0);
        step(8'h33, 8'h33, 8'h33, 3'b000, 3'b000, 1'b1);
        for (int i = 0; i < int'(SETTLE); i++)
            step(8'h44, 8'h44, 8'h44, 3'b000, 3'b000, 1'b0);
        // R4: stray acknowledge while idle has no effect
        step(8'h44, 8'h44, 8'h44, 3'b000, 3'b000, 1'b1);
        step(8'h44, 8'hFF, 8'h44, 3'b000, 3'b000, 1'b1);
        step(8'h44, 8'h44, 8'h44, 3'b000, 3'b000, 1'b0);
        // R1: two copies wrong the same way outvote the third
        step(8'h0F, 8'h0F, 8'hF0, 3'b000, 3'b000, 1'b0);
        // R7: drive counter to saturation
        for (int i = 0; i < 20; i++) begin
            step(8'h80, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1);
            step(8'h00, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1);
        end

        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, b, c;
            int sel;
            base = W'($urandom);
            a = base; b = base; c = base;
            sel = int'($urandom_range(0, 9));
            if (sel < 3)       a = base ^ W'($urandom);
            else if (sel < 5)  b = base ^ W'($urandom);
            else if (sel == 5) c = base ^ W'($urandom);
            else if (sel == 6) begin b = base ^ W'($urandom); c = base ^ W'($urandom); end
            step(a, b, c,
                 ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000,
                 ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
                 $urandom_range(0, 3) == 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule